// File: doc/BRIEF.md
# Pin Change Interrupt Controller

This block raises an interrupt when any line of a general-purpose I/O port changes level. Each pin is brought into the clock domain by a synchronizer. The synchronized level is compared with its value one cycle earlier. A rising or a falling change sets that line's bit in a sticky status word. The status word is combined with a per-line mask to drive a single interrupt output.

Software controls the mask through two write strobes that share one data bus. The set strobe turns mask bits on and the clear strobe turns them off, so the mask is never written directly.

A read strobe returns the status word and clears it on the following edge. The synchronized pin levels can be read at any time. Status bits are recorded even on masked lines, so unmasking a line that has a pending change raises the interrupt at once.

Top module: `pin_change_irq`

## Requirements
- R1: A rising or a falling level change on any line sets that line's status bit. `status_o` shows the bit after the third clock edge following the pin change.
- R2: With `mask_set_i` high, every bit that is 1 in `wdata_i` sets the matching mask bit on the next edge. Bits that are 0 in `wdata_i` leave the mask unchanged.
- R3: With `mask_clr_i` high, every bit that is 1 in `wdata_i` clears the matching mask bit. When both strobes are high in the same cycle, the clear wins.
- R4: `irq_o` is high exactly when at least one line has both its status bit and its mask bit set.
- R5: While `stat_rd_i` is high, `status_o` still shows the current status. Every status bit is zero after that edge unless a new change arrives.
- R6: A change detected in the same cycle as a status read is kept set after the clear.
- R7: Status bits are set on masked lines as well. Setting the mask bit of a line with a pending status raises `irq_o` right after the mask write edge.
- R8: `pin_level_o` shows each pin's level after two clock edges.
- R9: After reset, the mask and the status are zero and `irq_o` is low. Pins held at a steady level, whether 0 or 1, through and after reset report no change.
- R10: Status bits stay set, with no reads, while the mask and the pins change elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pins_i | input | NUM_LINES | Asynchronous pin levels |
| mask_set_i | input | 1 | Strobe that sets the mask bits selected by `wdata_i` |
| mask_clr_i | input | 1 | Strobe that clears the mask bits selected by `wdata_i` |
| wdata_i | input | NUM_LINES | Bit select for the mask strobes |
| stat_rd_i | input | 1 | Status read strobe; clears the status after this cycle |
| mask_o | output | NUM_LINES | Current interrupt mask |
| status_o | output | NUM_LINES | Sticky change status |
| pin_level_o | output | NUM_LINES | Synchronized pin levels |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong previous-sample register would show up in `status_o`. It gives either spurious bits just after reset or missing bits three edges after a pin toggle. A wrong clear ordering shows up on the edge after a read. Either every bit survives that edge, or an event that coincided with the read vanishes. Mask faults show up one edge after a strobe, both in `mask_o` and in whether `irq_o` follows a pending status bit. The bench samples every output on a falling edge. A single-cycle error in the synchronizer depth or the detection gating therefore appears as a mismatch at the exact expected edge.

// File: rtl/pin_change_irq_pkg.sv
package pin_change_irq_pkg;
  localparam int unsigned DEF_LINES = 32;
  localparam int unsigned DEF_SYNC  = 2;
endpackage

// File: rtl/pci_sync.sv
module pci_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pci_detect.sv
module pci_detect #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] chg_o
);
  // prev_q holds true pin data only once the synchronizer has filled
  localparam int unsigned ARM_CNT = STAGES + 1;
  localparam int unsigned CNT_W   = $clog2(ARM_CNT + 1);

  logic [CNT_W-1:0] warm_q;
  logic [WIDTH-1:0] prev_q;
  logic             armed;

  assign armed = (warm_q == CNT_W'(ARM_CNT));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     warm_q <= '0;
    else if (!armed) warm_q <= warm_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;

  assign chg_o = armed ? (lvl_i ^ prev_q) : '0;

  // R1
  level_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(armed)) |-> (chg_o == (lvl_i ^ $past(lvl_i))));
endmodule

// File: rtl/pci_status.sv
module pci_status #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] chg_i,
  input  logic             rd_i,
  output logic [WIDTH-1:0] status_o
);
  logic [WIDTH-1:0] status_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) status_q <= '0;
    else         status_q <= (rd_i ? '0 : status_q) | chg_i;

  assign status_o = status_q;

  // R1
  chg_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg_i != '0) |=> ((status_q & $past(chg_i)) == $past(chg_i)));
  // R5
  rd_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && chg_i == '0) |=> (status_q == '0));
  // R10
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> ((status_q & $past(status_q)) == $past(status_q)));
endmodule

// File: rtl/pci_mask.sv
module pci_mask #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] mask_o
);
  logic [WIDTH-1:0] mask_q, set_bits, clr_bits;

  assign set_bits = set_i ? wdata_i : '0;
  assign clr_bits = clr_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) mask_q <= '0;
    else         mask_q <= (mask_q | set_bits) & ~clr_bits;

  assign mask_o = mask_q;

  // R2
  mask_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clr_i) |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));
  // R3
  mask_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ((mask_q & $past(wdata_i)) == '0));
  // R2
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(mask_q));
endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq
  import pin_change_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES   = DEF_LINES,
  parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] pins_i,
  input  logic                 mask_set_i,
  input  logic                 mask_clr_i,
  input  logic [NUM_LINES-1:0] wdata_i,
  input  logic                 stat_rd_i,
  output logic [NUM_LINES-1:0] mask_o,
  output logic [NUM_LINES-1:0] status_o,
  output logic [NUM_LINES-1:0] pin_level_o,
  output logic                 irq_o
);
  logic [NUM_LINES-1:0] lvl, chg, status, mask;

  pci_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .d_i(pins_i), .q_o(lvl));

  pci_detect #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) i_detect (
    .clk_i, .rst_ni, .lvl_i(lvl), .chg_o(chg));

  pci_status #(.WIDTH(NUM_LINES)) i_status (
    .clk_i, .rst_ni, .chg_i(chg), .rd_i(stat_rd_i), .status_o(status));

  pci_mask #(.WIDTH(NUM_LINES)) i_mask (
    .clk_i, .rst_ni, .set_i(mask_set_i), .clr_i(mask_clr_i),
    .wdata_i, .mask_o(mask));

  assign irq_o       = |(status & mask);
  assign mask_o      = mask;
  assign status_o    = status;
  assign pin_level_o = lvl;

  // R6
  rd_keeps_new_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd_i |=> (status_o == $past(chg)));
endmodule

// File: tb/test_pin_change_irq.sv
module test_pin_change_irq;
  localparam int W = 32;

  typedef struct packed {
    logic [W-1:0] pins;
    logic         set;
    logic         clr;
    logic [W-1:0] wdata;
    logic         rd;
    logic [W-1:0] exp_st;
    logic [W-1:0] exp_mask;
    logic         exp_irq;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{pins:32'h0000_0000, set:0, clr:0, wdata:32'h0,         rd:0, exp_st:32'h0,         exp_mask:32'h0,         exp_irq:0},
    '{pins:32'h0000_0001, set:0, clr:0, wdata:32'h0,         rd:0, exp_st:32'h1,         exp_mask:32'h0,         exp_irq:0},
    '{pins:32'h0000_0001, set:1, clr:0, wdata:32'h1,         rd:0, exp_st:32'h1,         exp_mask:32'h1,         exp_irq:1},
    '{pins:32'h0000_0000, set:0, clr:0, wdata:32'h0,         rd:1, exp_st:32'h1,         exp_mask:32'h1,         exp_irq:1},
    '{pins:32'h0000_0000, set:0, clr:0, wdata:32'h0,         rd:1, exp_st:32'h0,         exp_mask:32'h1,         exp_irq:0},
    '{pins:32'hF000_0000, set:1, clr:0, wdata:32'h0000_00F0, rd:0, exp_st:32'hF000_0000, exp_mask:32'h0000_00F1, exp_irq:0},
    '{pins:32'hF000_0000, set:1, clr:0, wdata:32'h1000_0000, rd:0, exp_st:32'hF000_0000, exp_mask:32'h1000_00F1, exp_irq:1},
    '{pins:32'hF000_0000, set:0, clr:1, wdata:32'h0000_0001, rd:0, exp_st:32'hF000_0000, exp_mask:32'h1000_00F0, exp_irq:1},
    '{pins:32'hF000_0000, set:1, clr:1, wdata:32'h1000_0000, rd:0, exp_st:32'hF000_0000, exp_mask:32'h0000_00F0, exp_irq:0},
    '{pins:32'hF000_0000, set:0, clr:0, wdata:32'h0,         rd:1, exp_st:32'h0,         exp_mask:32'h0000_00F0, exp_irq:0},
    '{pins:32'h0000_0F0F, set:0, clr:0, wdata:32'h0,         rd:0, exp_st:32'hF000_0F0F, exp_mask:32'h0000_00F0, exp_irq:0},
    '{pins:32'h0000_0F0F, set:0, clr:1, wdata:32'hFFFF_FFFF, rd:0, exp_st:32'hF000_0F0F, exp_mask:32'h0,         exp_irq:0}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] pins = 32'hA5A5_A5A5;
  logic         mset = 1'b0, mclr = 1'b0, rd = 1'b0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] mask, status, lvl;
  logic         irq;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  pin_change_irq i_pin_change_irq (
    .clk_i(clk), .rst_ni(rst_n), .pins_i(pins), .mask_set_i(mset),
    .mask_clr_i(mclr), .wdata_i(wdata), .stat_rd_i(rd), .mask_o(mask),
    .status_o(status), .pin_level_o(lvl), .irq_o(irq));

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R9: steady nonzero pins across reset report nothing
    edges(3);
    rst_n = 1'b1;
    edges(6);
    chk("R9 status", status, '0);
    chk("R9 mask", mask, '0);
    chk("R9 irq", {31'b0, irq}, 32'h0);
    chk("R8 level", lvl, 32'hA5A5_A5A5);
    // R9: steady low pins across reset report nothing
    pins = '0;
    rst_n = 1'b0;
    edges(2);
    rst_n = 1'b1;
    edges(6);
    chk("R9 status low", status, '0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      pins = VECS[i].pins; mset = VECS[i].set; mclr = VECS[i].clr;
      wdata = VECS[i].wdata; rd = VECS[i].rd;
      edges(1);
      mset = 1'b0; mclr = 1'b0; rd = 1'b0;
      edges(2);
      chk($sformatf("R1/R10 st v%0d", i), status, VECS[i].exp_st);
      chk($sformatf("R2/R3 mask v%0d", i), mask, VECS[i].exp_mask);
      chk($sformatf("R4 irq v%0d", i), {31'b0, irq}, {31'b0, VECS[i].exp_irq});
      chk($sformatf("R8 lvl v%0d", i), lvl, VECS[i].pins);
    end

    // R8 latency: level old after one edge, new after two
    rd = 1'b1; edges(1); rd = 1'b0;
    pins = 32'h0000_0F0E;
    edges(1);
    chk("R8 lvl one edge", lvl, 32'h0000_0F0F);
    edges(1);
    chk("R8 lvl two edges", lvl, 32'h0000_0F0E);
    // R1 latency: the status bit appears on the third edge
    chk("R1 st before third edge", status, '0);
    edges(1);
    chk("R1 st third edge", status, 32'h1);

    // R6: a change in the read cycle survives; R5: the value is visible during the read
    pins = 32'h0000_0F1E;
    edges(2);
    rd = 1'b1;
    chk("R5 visible during read", status, 32'h1);
    edges(1);
    rd = 1'b0;
    chk("R6 new event kept", status, 32'h10);

    // R7: masked pending bit raises irq one edge after unmasking
    chk("R7 irq masked", {31'b0, irq}, 32'h0);
    mset = 1'b1; wdata = 32'h10;
    edges(1);
    mset = 1'b0;
    chk("R7 irq after unmask", {31'b0, irq}, 32'h1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule